// File: doc/BRIEF.md
# SPI Flash Erase Command Controller

This block is the serial command front end of a small two-sector user flash. A host acting as SPI master lowers the chip select, clocks in an 8-bit opcode most significant bit first, and raises the chip select again. The block recognises five commands: write-enable set, write-enable clear, status read, sector erase and chip erase. Erase commands are decoded and started only when the chip select returns high. They are gated by a write-enable latch and by per-sector protect inputs.

An accepted erase issues a one-cycle strobe per target sector toward the flash array. It then holds a not-ready flag for a fixed, parameterised number of clock cycles, which stands in for the self-timed erase. The host polls that flag through the status read. A mode input selects extended or base addressing. In extended mode a chip erase covers both sectors. In base mode a chip erase behaves exactly like a sector erase and touches sector 0 only. SCK, chip select and data are treated as synchronous to the system clock and must be oversampled by it.

Top module: `uflash_erase_ctrl`

## Requirements
- R1: While reset is high and right after it, notReady is 0, eraseStrobe is 0, soOe is 0 and the write-enable latch is clear.
- R2: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it; the latch is visible as status bit 1.
- R3: After the 8 bits of opcode 0x05, the status byte is shifted out on so, most significant bit first. Each bit is updated on the falling SCK edge and is valid at the next rising edge, with soOe high. The byte holds notReady in bit 0, write-enable in bit 1, sectorProtect[0] in bit 2, sectorProtect[1] in bit 3 and zeros in bits 7 to 4.
- R4: Chip erase (0x60) in extended mode (extMode=1) pulses eraseStrobe=2'b11 for exactly one cycle.
- R5: Chip erase in base mode (extMode=0) pulses eraseStrobe=2'b01 only.
- R6: Sector erase (0x20) pulses eraseStrobe=2'b01 in either mode.
- R7: A command takes effect only at the chip-select rising edge after exactly 8 SCK rising edges; a transfer with any other bit count is discarded.
- R8: An erase command with the write-enable latch clear is ignored.
- R9: An erase whose target set includes a protected sector is ignored as a whole.
- R10: An accepted erase raises notReady in the same cycle as the strobe and holds it for exactly ERASE_CYCLES clock cycles; write-enable clears when it ends.
- R11: While notReady is high, erase and write-enable commands are ignored and do not restart the erase time.
- R12: soOe stays low for the whole transfer of every command other than the status read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial lines |
| rst | input | 1 | Asynchronous active-high reset |
| sck | input | 1 | Serial clock from the host |
| csN | input | 1 | Active-low chip select |
| si | input | 1 | Serial data from the host |
| so | output | 1 | Serial status data to the host |
| soOe | output | 1 | Output enable for so; low means high impedance |
| extMode | input | 1 | 1 = extended addressing, 0 = base addressing |
| sectorProtect | input | NUM_SECTORS | Per-sector erase protection |
| eraseStrobe | output | NUM_SECTORS | One-cycle erase request per sector |
| notReady | output | 1 | High while a self-timed erase runs |

## Verification
The assertions assume that sck, csN, si, extMode and sectorProtect change only between system clock edges and stay stable long enough for each SCK level to be seen for at least one clock. They also assume that extMode and the protect bits do not move in the cycle a chip select rise is decoded. The stimulus drives every input on the falling clock edge. It holds each SCK phase for four clocks, and it changes mode and protection only while the chip select is high and idle. A behavioural model in the bench, built from counters and integers, predicts notReady and eraseStrobe on every clock. Directed status reads confirm the latch, protect and busy bits.

// File: rtl/uflash_pkg.sv
package uflash_pkg;
  localparam logic [7:0] OP_WRITE_ON     = 8'h06;
  localparam logic [7:0] OP_WRITE_OFF    = 8'h04;
  localparam logic [7:0] OP_READ_STATUS  = 8'h05;
  localparam logic [7:0] OP_SECTOR_ERASE = 8'h20;
  localparam logic [7:0] OP_CHIP_ERASE   = 8'h60;

  typedef struct packed {
    logic shiftIn;     // capture si on a rising SCK edge
    logic shiftOut;    // advance the status byte on a falling SCK edge
    logic loadStatus;  // load the status snapshot into the output shifter
    logic clearCount;  // chip select is high: clear the bit counter
  } dpStrobes_t;
endpackage

// File: rtl/uflash_shift_path.sv
module uflash_shift_path
  import uflash_pkg::*;
#(
  parameter int OP_BITS = 8,
  parameter int CNT_W   = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  dpStrobes_t         strobes,
  input  logic               si,
  input  logic [OP_BITS-1:0] statusByte,
  output logic [OP_BITS-1:0] opcode,
  output logic [CNT_W-1:0]   bitCount,
  output logic               soBit
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [OP_BITS-1:0] outShift;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      bitCount <= '0;
      opcode   <= '0;
      outShift <= '0;
    end else begin
      if (strobes.clearCount)
        bitCount <= '0;
      else if (strobes.shiftIn && bitCount != CNT_MAX)
        bitCount <= bitCount + 1'b1;

      if (strobes.shiftIn)
        opcode <= {opcode[OP_BITS-2:0], si};

      if (strobes.loadStatus)
        outShift <= statusByte;
      else if (strobes.shiftOut)
        outShift <= {outShift[OP_BITS-2:0], 1'b0};
    end
  end

  assign soBit = outShift[OP_BITS-1];

  // the bit count never wraps back to zero inside a transfer
  assert_count_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (bitCount != '0 && !strobes.clearCount) |=> bitCount != '0);
endmodule

// File: rtl/uflash_erase_timer.sv
module uflash_erase_timer #(
  parameter int ERASE_CYCLES = 5000,
  parameter int TMR_W        = $clog2(ERASE_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic finish
);
  localparam logic [TMR_W-1:0] LOAD_VAL = TMR_W'(ERASE_CYCLES - 1);

  logic [TMR_W-1:0] remaining;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      busy      <= 1'b0;
      remaining <= '0;
    end else if (start) begin
      busy      <= 1'b1;
      remaining <= LOAD_VAL;
    end else if (busy) begin
      if (remaining == '0) busy <= 1'b0;
      else remaining <= remaining - 1'b1;
    end
  end

  assign finish = busy && (remaining == '0);

  assert_no_restart_R11: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy);
  assert_finish_ends_R10: assert property (@(posedge clk) disable iff (rst)
    finish |=> !busy);
endmodule

// File: rtl/uflash_cmd_ctrl.sv
module uflash_cmd_ctrl
  import uflash_pkg::*;
#(
  parameter int NUM_SECTORS = 2,
  parameter int OP_BITS     = 8,
  parameter int CNT_W       = 5
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   sck,
  input  logic                   csN,
  input  logic                   extMode,
  input  logic [NUM_SECTORS-1:0] sectorProtect,
  input  logic [OP_BITS-1:0]     opcode,
  input  logic [CNT_W-1:0]       bitCount,
  input  logic                   busy,
  input  logic                   finish,
  output dpStrobes_t             strobes,
  output logic                   start,
  output logic [NUM_SECTORS-1:0] eraseStrobe,
  output logic [OP_BITS-1:0]     statusByte,
  output logic                   soOe
);
  localparam int ZPAD = OP_BITS - 2 - NUM_SECTORS;
  localparam logic [CNT_W-1:0] FULL_CMD = CNT_W'(OP_BITS);

  logic sckQ, csQ, wel, readActive;
  logic sckRise, sckFall, csRise, cmdValid;
  logic isChip, isSector, blocked;
  logic [NUM_SECTORS-1:0] targetMask;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      sckQ <= 1'b0;
      csQ  <= 1'b1;
    end else begin
      sckQ <= sck;
      csQ  <= csN;
    end
  end

  assign sckRise  = sck && !sckQ;
  assign sckFall  = !sck && sckQ;
  assign csRise   = csN && !csQ;
  assign cmdValid = csRise && (bitCount == FULL_CMD);
  assign isChip   = (opcode == OP_CHIP_ERASE);
  assign isSector = (opcode == OP_SECTOR_ERASE);

  // sector 0 is hit by every erase; the others only by chip erase in extended mode
  for (genvar s = 0; s < NUM_SECTORS; s++) begin : g_target
    if (s == 0) begin : g_first
      assign targetMask[s] = isChip || isSector;
    end else begin : g_rest
      assign targetMask[s] = isChip && extMode;
    end
  end

  assign blocked = |(targetMask & sectorProtect);
  assign start   = cmdValid && (isChip || isSector) && wel && !busy && !blocked;

  always_comb begin
    strobes            = '0;
    strobes.shiftIn    = sckRise && !csN;
    strobes.clearCount = csN;
    strobes.loadStatus = sckFall && !csN && !readActive &&
                         (bitCount == FULL_CMD) && (opcode == OP_READ_STATUS);
    strobes.shiftOut   = sckFall && !csN && readActive;
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      wel         <= 1'b0;
      readActive  <= 1'b0;
      eraseStrobe <= '0;
    end else begin
      eraseStrobe <= start ? targetMask : '0;

      if (csN) readActive <= 1'b0;
      else if (strobes.loadStatus) readActive <= 1'b1;

      if (finish) wel <= 1'b0;
      else if (cmdValid && !busy) begin
        if (opcode == OP_WRITE_ON) wel <= 1'b1;
        else if (opcode == OP_WRITE_OFF) wel <= 1'b0;
      end
    end
  end

  assign statusByte = {{ZPAD{1'b0}}, sectorProtect, wel, busy};
  assign soOe       = readActive && !csN;

  assert_strobe_single_R4: assert property (@(posedge clk) disable iff (rst)
    (|eraseStrobe) |=> (eraseStrobe == '0));
  assert_strobe_busy_R10: assert property (@(posedge clk) disable iff (rst)
    (|eraseStrobe) |-> busy);
  assert_base_sector0_R5: assert property (@(posedge clk) disable iff (rst)
    (eraseStrobe[NUM_SECTORS-1:1] != '0) |-> $past(extMode));
  assert_protect_R9: assert property (@(posedge clk) disable iff (rst)
    (|eraseStrobe) |-> (($past(sectorProtect) & eraseStrobe) == '0));
  assert_wel_gate_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(wel));
  assert_wel_clear_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> !wel);
  assert_so_hiz_R12: assert property (@(posedge clk) disable iff (rst)
    $rose(soOe) |-> (bitCount == FULL_CMD));
endmodule

// File: rtl/uflash_erase_ctrl.sv
module uflash_erase_ctrl
  import uflash_pkg::*;
#(
  parameter int NUM_SECTORS  = 2,
  parameter int ERASE_CYCLES = 5000
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   sck,
  input  logic                   csN,
  input  logic                   si,
  output logic                   so,
  output logic                   soOe,
  input  logic                   extMode,
  input  logic [NUM_SECTORS-1:0] sectorProtect,
  output logic [NUM_SECTORS-1:0] eraseStrobe,
  output logic                   notReady
);
  localparam int OP_BITS = 8;
  localparam int CNT_W   = $clog2(2 * OP_BITS) + 1;

  dpStrobes_t         strobes;
  logic [OP_BITS-1:0] opcode, statusByte;
  logic [CNT_W-1:0]   bitCount;
  logic               start, busy, finish;

  uflash_shift_path #(.OP_BITS(OP_BITS), .CNT_W(CNT_W)) u_path (
    .clk(clk), .rst(rst), .strobes(strobes), .si(si), .statusByte(statusByte),
    .opcode(opcode), .bitCount(bitCount), .soBit(so)
  );

  uflash_cmd_ctrl #(.NUM_SECTORS(NUM_SECTORS), .OP_BITS(OP_BITS), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .sck(sck), .csN(csN), .extMode(extMode),
    .sectorProtect(sectorProtect), .opcode(opcode), .bitCount(bitCount),
    .busy(busy), .finish(finish), .strobes(strobes), .start(start),
    .eraseStrobe(eraseStrobe), .statusByte(statusByte), .soOe(soOe)
  );

  uflash_erase_timer #(.ERASE_CYCLES(ERASE_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .finish(finish)
  );

  assign notReady = busy;
endmodule

// File: tb/uflash_erase_ctrl_test.sv
`timescale 1ns/1ps
module uflash_erase_ctrl_test;
  localparam int ERASE = 400;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sck = 1'b0, csN = 1'b1, si = 1'b0, extMode = 1'b0;
  logic [1:0] protect = 2'b00;
  logic so, soOe, notReady;
  logic [1:0] eraseStrobe;

  int checks = 0, errors = 0;
  bit finished = 0;
  string curReq = "R1";
  logic [1:0] seenStrobe = 2'b00;

  always #2.5 clk = ~clk;

  uflash_erase_ctrl #(.NUM_SECTORS(2), .ERASE_CYCLES(ERASE)) uut (
    .clk(clk), .rst(rst), .sck(sck), .csN(csN), .si(si), .so(so), .soOe(soOe),
    .extMode(extMode), .sectorProtect(protect), .eraseStrobe(eraseStrobe),
    .notReady(notReady)
  );

  // behavioural reference model, advanced on every rising clock
  int mCount, mTimer;
  logic [7:0] mOp;
  logic mSck, mCs, mBusy, mWel, oldBusy;
  logic [1:0] mStrobe, tgt;

  always @(posedge clk) begin
    if (rst) begin
      mCount = 0; mTimer = 0; mOp = 0; mSck = 0; mCs = 1;
      mBusy = 0; mWel = 0; mStrobe = 0;
    end else begin
      oldBusy = mBusy;
      mStrobe = 0;
      if (mBusy) begin
        if (mTimer == 0) begin mBusy = 0; mWel = 0; end
        else mTimer = mTimer - 1;
      end
      if (csN && !mCs && mCount == 8 && !oldBusy) begin
        case (mOp)
          8'h06: mWel = 1;
          8'h04: mWel = 0;
          8'h60, 8'h20: begin
            tgt = (mOp == 8'h60 && extMode) ? 2'b11 : 2'b01;
            if (mWel && (tgt & protect) == 2'b00) begin
              mBusy = 1; mTimer = ERASE - 1; mStrobe = tgt;
            end
          end
          default: ;
        endcase
      end
      if (csN) mCount = 0;
      else if (sck && !mSck) begin
        mOp = {mOp[6:0], si};
        if (mCount < 31) mCount = mCount + 1;
      end
      mSck = sck; mCs = csN;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (!rst && !finished) begin
      check({curReq, " R10 notReady"}, int'(notReady), int'(mBusy));
      check({curReq, " strobe"}, int'(eraseStrobe), int'(mStrobe));
      seenStrobe |= eraseStrobe;
    end
  end

  task automatic xfer(input logic [15:0] bits, input int n,
                      output logic [7:0] rd, output bit oe);
    rd = 0; oe = 0;
    csN = 1'b0;
    for (int i = 0; i < n; i++) begin
      si = bits[n-1-i];
      repeat (4) @(negedge clk);
      if (soOe) oe = 1;
      if (i >= 8) rd = {rd[6:0], so};
      sck = 1'b1;
      repeat (4) @(negedge clk);
      sck = 1'b0;
    end
    repeat (4) @(negedge clk);
    csN = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic cmd(input logic [7:0] op);
    logic [7:0] rd; bit oe;
    xfer({8'h00, op}, 8, rd, oe);
    check("R12 soOe during command", int'(oe), 0);
  endtask

  task automatic readStatus(input string req, input logic [7:0] exp);
    logic [7:0] rd; bit oe;
    xfer({8'h05, 8'h00}, 16, rd, oe);
    check("R3 soOe on read", int'(oe), 1);
    check({req, " status"}, int'(rd), int'(exp));
  endtask

  task automatic eraseCmd(input string req, input logic [7:0] op, input logic [1:0] exp);
    seenStrobe = 0;
    curReq = req;
    cmd(op);
    check({req, " strobe set"}, int'(seenStrobe), int'(exp));
  endtask

  task automatic waitIdle();
    repeat (ERASE + 4) @(negedge clk);
  endtask

  initial begin
    logic [7:0] rd; bit oe;
    repeat (3) @(negedge clk);
    check("R1 notReady in reset", int'(notReady), 0);
    check("R1 strobe in reset", int'(eraseStrobe), 0);
    check("R1 soOe in reset", int'(soOe), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    readStatus("R1", 8'h00);

    curReq = "R2";
    cmd(8'h06); readStatus("R2 set", 8'h02);
    cmd(8'h04); readStatus("R2 clear", 8'h00);

    extMode = 1'b1;
    cmd(8'h06);
    eraseCmd("R4", 8'h60, 2'b11);
    readStatus("R3 busy", 8'h03);
    waitIdle();
    readStatus("R10 done", 8'h00);

    extMode = 1'b0;
    cmd(8'h06);
    eraseCmd("R5", 8'h60, 2'b01);
    waitIdle();

    extMode = 1'b1;
    cmd(8'h06);
    eraseCmd("R6", 8'h20, 2'b01);
    waitIdle();

    eraseCmd("R8", 8'h60, 2'b00);
    readStatus("R8", 8'h00);

    protect = 2'b10;
    cmd(8'h06);
    eraseCmd("R9 ext", 8'h60, 2'b00);
    readStatus("R9", 8'h0A);
    extMode = 1'b0;
    eraseCmd("R9 base", 8'h60, 2'b01);
    waitIdle();
    protect = 2'b01;
    cmd(8'h06);
    eraseCmd("R9 sector", 8'h20, 2'b00);
    readStatus("R9 p0", 8'h06);
    cmd(8'h04);
    protect = 2'b00;

    curReq = "R7";
    cmd(8'h06);
    seenStrobe = 0;
    xfer(16'h0030, 7, rd, oe);
    check("R7 seven bits", int'(seenStrobe), 0);
    xfer(16'h0060, 9, rd, oe);
    check("R7 nine bits", int'(seenStrobe), 0);
    readStatus("R7", 8'h02);

    extMode = 1'b1;
    eraseCmd("R11 first", 8'h60, 2'b11);
    eraseCmd("R11 repeat", 8'h60, 2'b00);
    cmd(8'h06);
    waitIdle();
    readStatus("R11", 8'h00);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule